// File: doc/BRIEF.md
# Character LCD Command Receiver

This block sits on the receiving end of a parallel character-display bus. It watches the register-select, read/write, enable and eight data pins, and passes them through a synchroniser. Each transfer is taken on the falling edge of enable. In full-width mode a single strobe carries a whole byte. In half-width mode two strobes carry the upper four bits and then the lower four, both on the top four data pins. The rebuilt byte is either a controller instruction or a character code.

Instructions are classified by the position of their highest set bit. They update an address counter, a display view offset, the entry behaviour, the display, cursor and blink flags, the line count, the font and the bus width. Character codes are stored in one of two memories, the display memory or the glyph-definition memory, whichever was last selected by an address instruction. A read port lets a test environment inspect both memories.

Every accepted byte starts an execution window that is counted in microsecond ticks. Clear and home use the long window and everything else uses the short one. Reset opens a power-up window. A byte that completes while the window is open is dropped and raises a sticky misuse flag.

Top module: `chlcd_rx_decoder`

## Requirements
- R1: After reset, the bus is full width, the address counter and view offset are 0, increment is selected, shift, display, cursor and blink are off, one line and the small font are selected, and misuse is 0. busy stays high for POWERUP_US ticks.
- R2: A transfer is taken on the falling edge of enable. A strobe with read/write high (1 = read) is ignored and changes no state.
- R3: With select high (1 = character), the byte is stored at the address counter. The counter then moves by +1 if increment is set, or -1 if it is clear, and wraps in 7 bits for the display memory.
- R4: An instruction 0b000001_I_S sets increment to bit 1 and auto-shift to bit 0. With auto-shift set, each character write also moves the view offset by +1 (increment) or -1 (decrement).
- R5: An instruction 0b00001_D_C_B sets display-on from bit 2, cursor-on from bit 1 and blink from bit 0.
- R6: An instruction 0b0001_SC_RL_xx moves the view offset (bit 3 = 1) or the address counter (bit 3 = 0) by +1 when bit 2 is 1 and by -1 when it is 0. Bits 1..0 are ignored.
- R7: An instruction 0b001_DL_N_F_xx sets full-width bus from bit 4 and two-line from bit 3. The large font is set from bit 2 only when bit 3 is 0; otherwise it is cleared.
- R8: 0b01_AAAAAA sets the address counter to the 6-bit value and selects the glyph memory. 0b1_AAAAAAA sets the 7-bit value and selects the display memory. While the glyph memory is selected, the counter wraps in 6 bits.
- R9: 0x01 fills every display-memory entry with 0x20, sets the counter and view offset to 0, selects increment and selects the display memory. 0x02 and 0x03 set the counter and view offset to 0, select the display memory and keep memory contents.
- R10: After an accepted byte, busy stays high for LONG_US ticks for clear and home, and for SHORT_US ticks for every other byte. For clear, busy also stays high until the fill is done.
- R11: A byte completed while busy is high changes no state and sets misuse, which stays set until reset.
- R12: In half-width mode (full-width = 0), a byte is two strobes on data pins 7..4, upper nibble first. A single strobe of 0x3 on pins 7..4 in full-width mode is a complete function-set byte.
- R13: peek_data returns the entry at peek_addr one cycle after the address is applied, from the glyph memory when peek_cg is 1 and from the display memory otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| lcd_en | input | 1 | Bus enable strobe pin |
| lcd_sel | input | 1 | Register select pin, 1 = character data |
| lcd_rdwr | input | 1 | Read/write pin, 1 = read |
| lcd_bus | input | 8 | Data pins |
| busy | output | 1 | Execution or power-up window open |
| misuse | output | 1 | Sticky flag for a byte dropped while busy |
| addr_ctr | output | DD_AW | Address counter |
| view_ofs | output | DD_AW | Display view offset |
| cg_target | output | 1 | Glyph memory selected for writes |
| wide_bus | output | 1 | Full-width bus mode |
| two_line | output | 1 | Two-line mode |
| big_font | output | 1 | Large font selected |
| disp_on | output | 1 | Display on |
| curs_on | output | 1 | Cursor on |
| blink_on | output | 1 | Cursor blink |
| step_inc | output | 1 | Address counter increments |
| auto_shift | output | 1 | View shifts on each character write |
| peek_cg | input | 1 | Read port memory select |
| peek_addr | input | DD_AW | Read port address |
| peek_data | output | 8 | Read port data, one cycle latency |

## Verification
The bench writes a character at address 0 with decrement selected and one at address 127 with increment selected. A counter that saturates instead of wrapping shows the wrong address after either write. It writes to the glyph memory at its top address to catch a counter that runs past 6 bits. It times a home instruction against a display-control instruction at sample points where a long window and a short window give opposite busy levels. It sends an instruction during the open window, and a design that does not drop it leaves the display flags changed. It also checks that a lone 0x3 strobe after reset is taken as a whole byte, so that a decoder which pairs nibbles too early merges it with the byte that follows.

// File: rtl/chlcd_pkg.sv
package chlcd_pkg;

  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] BLANK_CHAR = 8'h20;

  typedef enum logic [3:0] {
    OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
    OP_SHIFT, OP_FUNC, OP_CGADR, OP_DDADR
  } op_e;

  typedef struct packed {
    logic wide;
    logic two_line;
    logic big_font;
    logic disp;
    logic curs;
    logic blink;
    logic inc;
    logic shift;
  } mode_t;

  // Instruction class is set by the highest set bit of the byte.
  function automatic op_e classify(input logic [CMD_W-1:0] b);
    if (b[7])      return OP_DDADR;
    else if (b[6]) return OP_CGADR;
    else if (b[5]) return OP_FUNC;
    else if (b[4]) return OP_SHIFT;
    else if (b[3]) return OP_DISP;
    else if (b[2]) return OP_ENTRY;
    else if (b[1]) return OP_HOME;
    else if (b[0]) return OP_CLEAR;
    else           return OP_NOP;
  endfunction

endpackage

// File: rtl/chlcd_pin_sync.sv
module chlcd_pin_sync #(
  parameter int STAGES = 2,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_e,
  input  logic          pin_rs,
  input  logic          pin_rw,
  input  logic [DW-1:0] pin_d,
  output logic          cap_valid,
  output logic          cap_rs,
  output logic          cap_rw,
  output logic [DW-1:0] cap_d
);
  localparam int W = DW + 3;

  logic [W-1:0] stage [STAGES];
  logic         e_now, e_prev;

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= {pin_e, pin_rs, pin_rw, pin_d};
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign e_now = stage[STAGES-1][W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      e_prev    <= 1'b0;
      cap_valid <= 1'b0;
      cap_rs    <= 1'b0;
      cap_rw    <= 1'b0;
      cap_d     <= '0;
    end else begin
      e_prev    <= e_now;
      cap_valid <= e_prev & ~e_now;
      if (e_prev && !e_now) begin
        cap_rs <= stage[STAGES-1][W-2];
        cap_rw <= stage[STAGES-1][W-3];
        cap_d  <= stage[STAGES-1][DW-1:0];
      end
    end
  end

  // R2: one capture per falling edge of enable
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cap_valid |=> !cap_valid);

endmodule

// File: rtl/chlcd_nibble_join.sv
module chlcd_nibble_join #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide,
  input  logic          cap_valid,
  input  logic          cap_rs,
  input  logic          cap_rw,
  input  logic [DW-1:0] cap_d,
  output logic          byte_valid,
  output logic          byte_rs,
  output logic [DW-1:0] byte_d
);
  localparam int NW = DW / 2;

  logic          phase;
  logic [NW-1:0] hi_q;
  logic          hi_rs;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= 1'b0;
      hi_q       <= '0;
      hi_rs      <= 1'b0;
      byte_valid <= 1'b0;
      byte_rs    <= 1'b0;
      byte_d     <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (wide) phase <= 1'b0;
      if (cap_valid && !cap_rw) begin
        if (wide) begin
          byte_valid <= 1'b1;
          byte_rs    <= cap_rs;
          byte_d     <= cap_d;
        end else if (!phase) begin
          hi_q  <= cap_d[DW-1:NW];
          hi_rs <= cap_rs;
          phase <= 1'b1;
        end else begin
          byte_valid <= 1'b1;
          byte_rs    <= hi_rs;
          byte_d     <= {hi_q, cap_d[DW-1:NW]};
          phase      <= 1'b0;
        end
      end
    end
  end

  // R2: a byte only follows a write strobe, never a read strobe
  a_r2_write_only: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(cap_valid && !cap_rw));

endmodule

// File: rtl/chlcd_busy_timer.sv
module chlcd_busy_timer #(
  parameter int CW    = 16,
  parameter int INITV = 40000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= CW'(INITV);
    else if (load)             cnt <= load_val;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R10: the window only shrinks on a microsecond tick
  a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/chlcd_dpram.sv
module chlcd_dpram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/chlcd_rx_decoder.sv
module chlcd_rx_decoder
  import chlcd_pkg::*;
#(
  parameter int DD_DEPTH    = 128,
  parameter int CG_DEPTH    = 64,
  parameter int DD_AW       = $clog2(DD_DEPTH),
  parameter int SYNC_STAGES = 2,
  parameter int POWERUP_US  = 40000,
  parameter int LONG_US     = 1520,
  parameter int SHORT_US    = 37
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             us_tick,
  input  logic             lcd_en,
  input  logic             lcd_sel,
  input  logic             lcd_rdwr,
  input  logic [CMD_W-1:0] lcd_bus,
  output logic             busy,
  output logic             misuse,
  output logic [DD_AW-1:0] addr_ctr,
  output logic [DD_AW-1:0] view_ofs,
  output logic             cg_target,
  output logic             wide_bus,
  output logic             two_line,
  output logic             big_font,
  output logic             disp_on,
  output logic             curs_on,
  output logic             blink_on,
  output logic             step_inc,
  output logic             auto_shift,
  input  logic             peek_cg,
  input  logic [DD_AW-1:0] peek_addr,
  output logic [CMD_W-1:0] peek_data
);
  localparam int CG_AW  = $clog2(CG_DEPTH);
  localparam int MAX_A  = (POWERUP_US > LONG_US) ? POWERUP_US : LONG_US;
  localparam int MAXV   = (MAX_A > SHORT_US) ? MAX_A : SHORT_US;
  localparam int CW     = $clog2(MAXV + 1);
  localparam logic [DD_AW-1:0] CG_MASK = DD_AW'(CG_DEPTH - 1);
  localparam logic [DD_AW-1:0] DD_LAST = DD_AW'(DD_DEPTH - 1);

  // capture and byte assembly
  logic             cap_valid, cap_rs, cap_rw;
  logic [CMD_W-1:0] cap_d;
  logic             byte_valid, byte_rs;
  logic [CMD_W-1:0] byte_d;

  // state
  mode_t            mode;
  logic [DD_AW-1:0] addr_q, ofs_q, fill_idx;
  logic             cg_q, fill_on, misuse_q, peek_cg_q;

  // execution
  op_e              op;
  logic             accept, timer_busy, long_op;
  logic [CW-1:0]    load_val;
  logic [DD_AW-1:0] ac_up, ac_dn;

  // memories
  logic             dd_we, cg_we;
  logic [DD_AW-1:0] dd_waddr;
  logic [CMD_W-1:0] dd_wdata, dd_rd, cg_rd;

  chlcd_pin_sync #(.STAGES(SYNC_STAGES), .DW(CMD_W)) u_sync (
    .clk(clk), .rst(rst), .pin_e(lcd_en), .pin_rs(lcd_sel), .pin_rw(lcd_rdwr),
    .pin_d(lcd_bus), .cap_valid(cap_valid), .cap_rs(cap_rs), .cap_rw(cap_rw),
    .cap_d(cap_d));

  chlcd_nibble_join #(.DW(CMD_W)) u_join (
    .clk(clk), .rst(rst), .wide(mode.wide), .cap_valid(cap_valid),
    .cap_rs(cap_rs), .cap_rw(cap_rw), .cap_d(cap_d),
    .byte_valid(byte_valid), .byte_rs(byte_rs), .byte_d(byte_d));

  assign op       = classify(byte_d);
  assign accept   = byte_valid && !busy;
  assign long_op  = !byte_rs && (op == OP_CLEAR || op == OP_HOME);
  assign load_val = long_op ? CW'(LONG_US) : CW'(SHORT_US);

  chlcd_busy_timer #(.CW(CW), .INITV(POWERUP_US)) u_timer (
    .clk(clk), .rst(rst), .tick(us_tick), .load(accept),
    .load_val(load_val), .busy(timer_busy));

  assign busy = timer_busy | fill_on;

  // address steps; glyph memory wraps in fewer bits
  always_comb begin
    ac_up = addr_q + 1'b1;
    ac_dn = addr_q - 1'b1;
    if (cg_q) begin
      ac_up = ac_up & CG_MASK;
      ac_dn = ac_dn & CG_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= '{wide: 1'b1, two_line: 1'b0, big_font: 1'b0, disp: 1'b0,
                    curs: 1'b0, blink: 1'b0, inc: 1'b1, shift: 1'b0};
      addr_q   <= '0;
      ofs_q    <= '0;
      cg_q     <= 1'b0;
      fill_on  <= 1'b0;
      fill_idx <= '0;
      misuse_q <= 1'b0;
    end else begin
      if (fill_on) begin
        fill_idx <= fill_idx + 1'b1;
        if (fill_idx == DD_LAST) fill_on <= 1'b0;
      end
      if (byte_valid && busy) misuse_q <= 1'b1;
      if (accept) begin
        if (byte_rs) begin
          addr_q <= mode.inc ? ac_up : ac_dn;
          if (mode.shift) ofs_q <= mode.inc ? ofs_q + 1'b1 : ofs_q - 1'b1;
        end else begin
          unique case (op)
            OP_CLEAR: begin
              addr_q   <= '0;
              ofs_q    <= '0;
              cg_q     <= 1'b0;
              mode.inc <= 1'b1;
              fill_on  <= 1'b1;
              fill_idx <= '0;
            end
            OP_HOME: begin
              addr_q <= '0;
              ofs_q  <= '0;
              cg_q   <= 1'b0;
            end
            OP_ENTRY: begin
              mode.inc   <= byte_d[1];
              mode.shift <= byte_d[0];
            end
            OP_DISP: begin
              mode.disp  <= byte_d[2];
              mode.curs  <= byte_d[1];
              mode.blink <= byte_d[0];
            end
            OP_SHIFT: begin
              if (byte_d[3]) ofs_q  <= byte_d[2] ? ofs_q + 1'b1 : ofs_q - 1'b1;
              else           addr_q <= byte_d[2] ? ac_up : ac_dn;
            end
            OP_FUNC: begin
              mode.wide     <= byte_d[4];
              mode.two_line <= byte_d[3];
              mode.big_font <= byte_d[2] & ~byte_d[3];
            end
            OP_CGADR: begin
              addr_q <= DD_AW'(byte_d[5:0]) & CG_MASK;
              cg_q   <= 1'b1;
            end
            OP_DDADR: begin
              addr_q <= byte_d[DD_AW-1:0];
              cg_q   <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // memory write steering: the clear fill owns the display port while active
  assign dd_we    = fill_on | (accept & byte_rs & ~cg_q);
  assign dd_waddr = fill_on ? fill_idx : addr_q;
  assign dd_wdata = fill_on ? BLANK_CHAR : byte_d;
  assign cg_we    = accept & byte_rs & cg_q;

  chlcd_dpram #(.DEPTH(DD_DEPTH), .DW(CMD_W), .AW(DD_AW)) u_ddram (
    .clk(clk), .we(dd_we), .waddr(dd_waddr), .wdata(dd_wdata),
    .raddr(peek_addr), .rdata(dd_rd));

  chlcd_dpram #(.DEPTH(CG_DEPTH), .DW(CMD_W), .AW(CG_AW)) u_cgram (
    .clk(clk), .we(cg_we), .waddr(addr_q[CG_AW-1:0]), .wdata(byte_d),
    .raddr(peek_addr[CG_AW-1:0]), .rdata(cg_rd));

  always_ff @(posedge clk) begin
    if (rst) peek_cg_q <= 1'b0;
    else     peek_cg_q <= peek_cg;
  end

  assign peek_data  = peek_cg_q ? cg_rd : dd_rd;
  assign misuse     = misuse_q;
  assign addr_ctr   = addr_q;
  assign view_ofs   = ofs_q;
  assign cg_target  = cg_q;
  assign wide_bus   = mode.wide;
  assign two_line   = mode.two_line;
  assign big_font   = mode.big_font;
  assign disp_on    = mode.disp;
  assign curs_on    = mode.curs;
  assign blink_on   = mode.blink;
  assign step_inc   = mode.inc;
  assign auto_shift = mode.shift;

  // R11: misuse never clears on its own
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    misuse_q |=> misuse_q);

  // R11: a byte arriving in the window leaves mode and address alone
  a_r11_no_effect: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && busy) |=> ($stable(mode) && $stable(addr_q) && $stable(ofs_q)));

  // R10: an accepted byte opens the window on the next cycle
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  // R8: glyph addressing never leaves the glyph memory range
  a_r8_cg_range: assert property (@(posedge clk) disable iff (rst)
    cg_q |-> ((addr_q & ~CG_MASK) == '0));

  // R7: two-line mode never holds the large font
  a_r7_font_rule: assert property (@(posedge clk) disable iff (rst)
    mode.two_line |-> !mode.big_font);

endmodule

// File: tb/chlcd_rx_decoder_bench.sv
module chlcd_rx_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW_US = 50;
  localparam int LG_US = 40;
  localparam int SH_US = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       us_tick = 1'b0;
  logic       lcd_en = 1'b0, lcd_sel = 1'b0, lcd_rdwr = 1'b0;
  logic [7:0] lcd_bus = 8'h00;
  logic       busy, misuse, cg_target;
  logic [6:0] addr_ctr, view_ofs, peek_addr = 7'd0;
  logic       wide_bus, two_line, big_font, disp_on, curs_on, blink_on, step_inc, auto_shift;
  logic       peek_cg = 1'b0;
  logic [7:0] peek_data;

  int  n_run = 0, n_fail = 0;
  bit  narrow_tb = 1'b0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chlcd_rx_decoder #(.POWERUP_US(PW_US), .LONG_US(LG_US), .SHORT_US(SH_US)) u_chlcd_rx_decoder (
    .clk(clk), .rst(rst), .us_tick(us_tick), .lcd_en(lcd_en), .lcd_sel(lcd_sel),
    .lcd_rdwr(lcd_rdwr), .lcd_bus(lcd_bus), .busy(busy), .misuse(misuse),
    .addr_ctr(addr_ctr), .view_ofs(view_ofs), .cg_target(cg_target),
    .wide_bus(wide_bus), .two_line(two_line), .big_font(big_font), .disp_on(disp_on),
    .curs_on(curs_on), .blink_on(blink_on), .step_inc(step_inc), .auto_shift(auto_shift),
    .peek_cg(peek_cg), .peek_addr(peek_addr), .peek_data(peek_data));

  // {sel, byte, expected address, expected flags}
  // flags = {wide, two_line, big_font, disp, curs, blink, inc, shift}
  localparam logic [23:0] VEC [18] = '{
    {1'b0, 8'h38, 7'h00, 8'hC2}, {1'b0, 8'h34, 7'h00, 8'hA2},
    {1'b0, 8'h3C, 7'h00, 8'hC2}, {1'b0, 8'h0F, 7'h00, 8'hDE},
    {1'b0, 8'h0C, 7'h00, 8'hD2}, {1'b0, 8'h85, 7'h05, 8'hD2},
    {1'b1, 8'h41, 7'h06, 8'hD2}, {1'b1, 8'h42, 7'h07, 8'hD2},
    {1'b0, 8'h04, 7'h07, 8'hD0}, {1'b1, 8'h43, 7'h06, 8'hD0},
    {1'b0, 8'h14, 7'h07, 8'hD0}, {1'b0, 8'h10, 7'h06, 8'hD0},
    {1'b0, 8'h80, 7'h00, 8'hD0}, {1'b1, 8'h44, 7'h7F, 8'hD0},
    {1'b0, 8'h06, 7'h7F, 8'hD2}, {1'b1, 8'h45, 7'h00, 8'hD2},
    {1'b0, 8'h8A, 7'h0A, 8'hD2}, {1'b0, 8'h03, 7'h00, 8'hD2}
  };

  function automatic string row_req(input int i);
    case (i)
      0, 1, 2:           return "R7";
      3, 4:              return "R5";
      5, 12, 16:         return "R8";
      6, 7, 9, 13, 15:   return "R3";
      8, 14:             return "R4";
      10, 11:            return "R6";
      default:           return "R9";
    endcase
  endfunction

  function automatic logic [7:0] flags();
    return {wide_bus, two_line, big_font, disp_on, curs_on, blink_on, step_inc, auto_shift};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic strobe(input logic rs, input logic rw, input logic [7:0] d);
    @(negedge clk);
    lcd_sel = rs; lcd_rdwr = rw; lcd_bus = d;
    repeat (2) @(negedge clk);
    lcd_en = 1'b1;
    repeat (4) @(negedge clk);
    lcd_en = 1'b0;
    repeat (4) @(negedge clk);
    lcd_rdwr = 1'b0;
  endtask

  task automatic send(input logic rs, input logic [7:0] d);
    if (narrow_tb) begin
      strobe(rs, 1'b0, {d[7:4], 4'h0});
      strobe(rs, 1'b0, {d[3:0], 4'h0});
    end else begin
      strobe(rs, 1'b0, d);
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    repeat (4) @(negedge clk);
    while (busy && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic peek(input logic cg, input logic [6:0] a, output logic [7:0] v);
    @(negedge clk);
    peek_cg = cg; peek_addr = a;
    repeat (2) @(negedge clk);
    v = peek_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // microsecond tick: one cycle in four
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;

    // R1: reset state
    do_reset();
    chk("R1 busy after reset", 32'(busy), 32'd1);
    chk("R1 address", 32'(addr_ctr), 32'd0);
    chk("R1 flags", 32'(flags()), 32'h82);
    chk("R1 misuse", 32'(misuse), 32'd0);
    chk("R1 view offset", 32'(view_ofs), 32'd0);
    repeat (150) @(negedge clk);
    chk("R1 power-up window still open", 32'(busy), 32'd1);
    wait_idle();
    chk("R1 power-up window closed", 32'(busy), 32'd0);

    // table walk: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 18; i++) begin
      send(VEC[i][23], VEC[i][22:15]);
      wait_idle();
      chk({row_req(i), " table address"}, 32'(addr_ctr), 32'(VEC[i][14:8]));
      chk({row_req(i), " table flags"}, 32'(flags()), 32'(VEC[i][7:0]));
    end

    // R6: display shift moves the view offset
    send(1'b0, 8'h18); wait_idle();
    chk("R6 view left", 32'(view_ofs), 32'h7F);
    send(1'b0, 8'h1C); wait_idle();
    chk("R6 view right", 32'(view_ofs), 32'h00);
    // R4: auto-shift on character write
    send(1'b0, 8'h07); wait_idle();
    send(1'b1, 8'h46); wait_idle();
    chk("R4 auto-shift offset", 32'(view_ofs), 32'h01);
    chk("R4 auto-shift address", 32'(addr_ctr), 32'h01);

    // R10: home is a long window, R9 home resets offset
    strobe(1'b0, 1'b0, 8'h02);
    repeat (140) @(negedge clk);
    chk("R10 long window at 140", 32'(busy), 32'd1);
    repeat (30) @(negedge clk);
    chk("R10 long window closed", 32'(busy), 32'd0);
    chk("R9 home address", 32'(addr_ctr), 32'd0);
    chk("R9 home offset", 32'(view_ofs), 32'd0);
    // R10: display control is a short window
    strobe(1'b0, 1'b0, 8'h0C);
    repeat (20) @(negedge clk);
    chk("R10 short window open", 32'(busy), 32'd1);
    repeat (20) @(negedge clk);
    chk("R10 short window closed", 32'(busy), 32'd0);

    // R13/R3: display memory contents
    peek(1'b0, 7'd5, v);   chk("R13 dd[5]", 32'(v), 32'h41);
    peek(1'b0, 7'd6, v);   chk("R3 dd[6]", 32'(v), 32'h42);
    peek(1'b0, 7'd7, v);   chk("R3 dd[7]", 32'(v), 32'h43);
    peek(1'b0, 7'd0, v);   chk("R3 dd[0]", 32'(v), 32'h46);
    peek(1'b0, 7'd127, v); chk("R3 dd[127]", 32'(v), 32'h45);

    // R8: glyph memory target and 6-bit wrap
    send(1'b0, 8'h48); wait_idle();
    chk("R8 cg address", 32'(addr_ctr), 32'd8);
    chk("R8 cg target", 32'(cg_target), 32'd1);
    send(1'b1, 8'h1F); wait_idle();
    chk("R8 cg step", 32'(addr_ctr), 32'd9);
    send(1'b0, 8'h7F); wait_idle();
    send(1'b1, 8'h11); wait_idle();
    chk("R8 cg wrap", 32'(addr_ctr), 32'd0);
    peek(1'b1, 7'd8, v);  chk("R13 cg[8]", 32'(v), 32'h1F);
    peek(1'b1, 7'd63, v); chk("R8 cg[63]", 32'(v), 32'h11);
    peek(1'b0, 7'd5, v);  chk("R8 dd untouched by cg write", 32'(v), 32'h41);
    send(1'b0, 8'h06); wait_idle();

    // R2: read strobes are ignored
    send(1'b0, 8'h90); wait_idle();
    strobe(1'b0, 1'b1, 8'h01);
    repeat (10) @(negedge clk);
    chk("R2 read strobe busy", 32'(busy), 32'd0);
    chk("R2 read strobe address", 32'(addr_ctr), 32'd16);
    strobe(1'b1, 1'b1, 8'h55);
    repeat (10) @(negedge clk);
    chk("R2 read strobe data address", 32'(addr_ctr), 32'd16);
    chk("R2 read strobe target", 32'(cg_target), 32'd0);

    // R11: a byte inside the window is dropped and flagged
    chk("R11 misuse clear before", 32'(misuse), 32'd0);
    strobe(1'b0, 1'b0, 8'h08);
    strobe(1'b0, 1'b0, 8'h0F);
    wait_idle();
    chk("R11 dropped byte flags", 32'(flags()), 32'hC2);
    chk("R11 misuse set", 32'(misuse), 32'd1);

    // R9: clear fills with blanks and restores increment
    send(1'b0, 8'h04); wait_idle();
    send(1'b0, 8'h01); wait_idle();
    chk("R9 clear address", 32'(addr_ctr), 32'd0);
    chk("R9 clear flags", 32'(flags()), 32'hC2);
    peek(1'b0, 7'd5, v);   chk("R9 clear dd[5]", 32'(v), 32'h20);
    peek(1'b0, 7'd127, v); chk("R9 clear dd[127]", 32'(v), 32'h20);

    // R12: switch to half-width and send nibble pairs
    strobe(1'b0, 1'b0, 8'h28); wait_idle();
    chk("R12 narrow mode flags", 32'(flags()), 32'h42);
    narrow_tb = 1'b1;
    send(1'b0, 8'h0E); wait_idle();
    chk("R12 nibble pair command", 32'(flags()), 32'h5A);
    send(1'b0, 8'h90); wait_idle();
    send(1'b1, 8'h5A); wait_idle();
    chk("R12 nibble data address", 32'(addr_ctr), 32'd17);
    peek(1'b0, 7'd16, v); chk("R12 nibble data", 32'(v), 32'h5A);

    // R1/R12: reset clears misuse; lone 0x3 strobe is a whole byte
    do_reset();
    narrow_tb = 1'b0;
    chk("R1 misuse after reset", 32'(misuse), 32'd0);
    chk("R1 flags after reset", 32'(flags()), 32'h82);
    wait_idle();
    strobe(1'b0, 1'b0, 8'h30); wait_idle();
    send(1'b0, 8'h0C); wait_idle();
    chk("R12 single 0x3 strobe", 32'(flags()), 32'h92);
    chk("R11 no misuse after spaced bytes", 32'(misuse), 32'd0);

    summary();
  end

endmodule